// File: doc/BRIEF.md
# Hit Time Clustering Chain

This block groups a stream of hit times into clusters. Hits that fall close to one another in time count as one physical event. The grouping is done by a linear chain of identical cells. Each cell owns at most one cluster and holds three things: the reference time (the first time it caught), a member count, and a signed sum of member offsets from the reference. A hit enters at cell 0 and moves one cell per clock. It joins the first occupied cell whose window contains it. If it reaches an empty cell first, that cell becomes a new cluster. Because of this, clusters always occupy a contiguous run of cells starting at cell 0, in order of creation.

Times are a coarse counter concatenated with an 8-bit fine part. Each cell stores the offset of a member from its reference, not the full time, so every sum stays narrow. For the same reason the averaging divider only works on the small offset sum and never on the full time word. The window below the reference and the window above it come from two independent limit inputs. With a fine step of 100 ps, the intended range is up to 125 steps (12.5 ns) per side.

A frame-end strobe closes the frame. The chain then waits for in-flight hits to settle. After that it turns into a shift register and unloads one cluster per clock through a three-stage averaging pipeline. It then comes back empty and ready for the next frame. A hit that passes the last cell without finding a home is dropped, and a sticky flag records the loss.

Top module: `hit_cluster_chain`

## Requirements
- R1: After reset, `hit_ready` is 1, `clu_valid` is 0 and `hit_lost` is 0.
- R2: An empty cell reached by a hit takes the hit's time as reference, with count 1 and offset sum 0.
- R3: A hit whose offset d = time - reference satisfies -`win_lo` <= d <= `win_hi` joins that cluster: the count rises by 1 and d is added to the signed offset sum.
- R4: A hit joins the first matching cell counting from cell 0, otherwise it passes on. Clusters are unloaded in order of creation, the oldest first.
- R5: The lower and upper windows are independent. An offset of exactly -`win_lo` or +`win_hi` joins, and one step beyond either limit does not.
- R6: A hit that leaves the last of `N_CELLS` cells unplaced is discarded and sets `hit_lost`, which stays 1 until reset.
- R7: A `frame_end` strobe while `hit_ready` is 1 drops `hit_ready`. Hits offered while `hit_ready` is 0 are ignored. Each cluster is emitted exactly once, and the chain is empty for the next frame. A frame with no hits emits nothing.
- R8: `clu_avg` = reference + (offset sum / count), with the quotient truncated toward zero. When no hit is in flight, the first cluster of a frame appears on the 4th rising edge after the edge that samples `frame_end`, and the remaining clusters follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hit_valid | input | 1 | Hit time present |
| hit_time | input | TIME_W (40) | Hit time, coarse part above an 8-bit fine part |
| frame_end | input | 1 | Closes the current frame and starts unloading |
| win_lo | input | WIN_W (8) | Allowed offset below the reference, in fine steps |
| win_hi | input | WIN_W (8) | Allowed offset above the reference, in fine steps |
| hit_ready | output | 1 | Block accepts hits and frame-end (idle phase) |
| clu_valid | output | 1 | Cluster result present |
| clu_ref | output | TIME_W (40) | Cluster reference time |
| clu_cnt | output | CNT_W (8) | Number of member hits |
| clu_sum | output | WIN_W+2+CNT_W (18) | Signed sum of member offsets from the reference |
| clu_avg | output | TIME_W (40) | Average cluster time |
| hit_lost | output | 1 | Sticky: a hit was discarded at the end of the chain |

## Verification
Clusters only become visible after a frame closes. The bench therefore compares the whole ordered output stream of each frame against a sequential greedy model, rather than matching one output to one input. Before each strobe it leaves a gap of `N_CELLS`+2 idle cycles so that no hit is in flight. The first result is then due exactly five falling-edge samples after the sample at which `frame_end` was driven: one edge to sample the strobe, one drain decision, and three divider stages. Every further cluster is due one cycle after the previous one. The bench timestamps every output with a cycle counter and checks both distances. Hits offered while `hit_ready` is low are driven only between edges at which the block is provably busy, and they must be absent from both the current and the following frame.

// File: rtl/tclu_pkg.sv
`timescale 1ns/1ps
package tclu_pkg;
  // phases of the chain controller
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DRAIN  = 2'd1,
    PH_UNLOAD = 2'd2
  } phase_e;
endpackage

// File: rtl/tclu_cell.sv
`timescale 1ns/1ps
module tclu_cell #(
  parameter int TIME_W = 40,
  parameter int WIN_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          shift_en,
  input  logic [WIN_W-1:0]              win_lo,
  input  logic [WIN_W-1:0]              win_hi,
  input  logic                          tok_v_i,
  input  logic [TIME_W-1:0]             tok_t_i,
  input  logic                          nb_occ_i,
  input  logic [TIME_W-1:0]             nb_ref_i,
  input  logic [CNT_W-1:0]              nb_cnt_i,
  input  logic [WIN_W+2+CNT_W-1:0]      nb_sum_i,
  output logic                          occ_o,
  output logic [TIME_W-1:0]             ref_o,
  output logic [CNT_W-1:0]              cnt_o,
  output logic [WIN_W+2+CNT_W-1:0]      sum_o,
  output logic                          tok_v_o,
  output logic [TIME_W-1:0]             tok_t_o
);
  localparam int DW    = WIN_W + 2;
  localparam int SUM_W = DW + CNT_W;
  localparam int PADW  = TIME_W + 1 - WIN_W;

  logic              occ_q, occ_n;
  logic [TIME_W-1:0] ref_q, ref_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SUM_W-1:0]  sum_q, sum_n;
  logic              tv_q, fwd_v;
  logic [TIME_W-1:0] tt_q;
  logic              st_en;

  logic signed [TIME_W:0] diff, lo_s, hi_s;
  logic              in_win;
  logic [DW-1:0]     delta;

  always_comb begin
    diff   = $signed({1'b0, tok_t_i}) - $signed({1'b0, ref_q});
    lo_s   = $signed({{PADW{1'b0}}, win_lo});
    hi_s   = $signed({{PADW{1'b0}}, win_hi});
    in_win = (diff >= -lo_s) && (diff <= hi_s);
    delta  = diff[DW-1:0];
  end

  // next-state of the cluster held by this cell
  always_comb begin
    occ_n = occ_q;
    ref_n = ref_q;
    cnt_n = cnt_q;
    sum_n = sum_q;
    fwd_v = 1'b0;
    if (shift_en) begin
      occ_n = nb_occ_i;
      ref_n = nb_ref_i;
      cnt_n = nb_cnt_i;
      sum_n = nb_sum_i;
    end else if (tok_v_i) begin
      if (!occ_q) begin
        occ_n = 1'b1;
        ref_n = tok_t_i;
        cnt_n = CNT_W'(1);
        sum_n = '0;
      end else if (in_win) begin
        cnt_n = cnt_q + CNT_W'(1);
        sum_n = sum_q + {{CNT_W{delta[DW-1]}}, delta};
      end else begin
        fwd_v = 1'b1;
      end
    end
  end

  assign st_en = shift_en | tok_v_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 1'b0;
      ref_q <= '0;
      cnt_q <= '0;
      sum_q <= '0;
      tv_q  <= 1'b0;
      tt_q  <= '0;
    end else begin
      if (st_en) begin
        occ_q <= occ_n;
        ref_q <= ref_n;
        cnt_q <= cnt_n;
        sum_q <= sum_n;
      end
      tv_q <= fwd_v;
      if (fwd_v) tt_q <= tok_t_i;
    end
  end

  assign occ_o   = occ_q;
  assign ref_o   = ref_q;
  assign cnt_o   = cnt_q;
  assign sum_o   = sum_q;
  assign tok_v_o = tv_q;
  assign tok_t_o = tt_q;

  // R2
  capture_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_v_i && !occ_q && !shift_en) |=> (occ_q && cnt_q == CNT_W'(1) && sum_q == '0));
  // R7
  shift_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !tok_v_i);
  // R4
  contiguous_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !occ_q |-> !nb_occ_i);
  // R3
  occupied_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q |-> (cnt_q != '0));
endmodule

// File: rtl/tclu_ctrl.sv
`timescale 1ns/1ps
module tclu_ctrl
  import tclu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic any_tok,
  input  logic head_occ,
  output logic accept_o,
  output logic shift_o
);
  phase_e ph_q, ph_n;

  always_comb begin
    ph_n = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (frame_end) ph_n = PH_DRAIN;
      PH_DRAIN:  if (!any_tok)  ph_n = PH_UNLOAD;
      PH_UNLOAD: if (!head_occ) ph_n = PH_IDLE;
      default:   ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_n;
  end

  assign accept_o = (ph_q == PH_IDLE);
  assign shift_o  = (ph_q == PH_UNLOAD);

  // R7
  unload_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_UNLOAD && !head_occ) |=> (ph_q == PH_IDLE));
  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DRAIN && any_tok) |=> (ph_q == PH_DRAIN));
endmodule

// File: rtl/tclu_avg.sv
`timescale 1ns/1ps
module tclu_avg #(
  parameter int TIME_W = 40,
  parameter int WIN_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_v,
  input  logic [TIME_W-1:0]        in_ref,
  input  logic [CNT_W-1:0]         in_cnt,
  input  logic [WIN_W+2+CNT_W-1:0] in_sum,
  output logic                     out_v,
  output logic [TIME_W-1:0]        out_ref,
  output logic [CNT_W-1:0]         out_cnt,
  output logic [WIN_W+2+CNT_W-1:0] out_sum,
  output logic [TIME_W-1:0]        out_avg
);
  localparam int SUM_W = WIN_W + 2 + CNT_W;
  localparam int QW    = WIN_W + 1;
  localparam int EXW   = TIME_W - QW - 1;

  // stage 1: sign and magnitude
  logic              s1_v, s1_neg;
  logic [TIME_W-1:0] s1_ref;
  logic [CNT_W-1:0]  s1_cnt;
  logic [SUM_W-1:0]  s1_sum, s1_mag, mag_n;
  // stage 2: quotient of magnitudes
  logic              s2_v, s2_neg;
  logic [TIME_W-1:0] s2_ref;
  logic [CNT_W-1:0]  s2_cnt;
  logic [SUM_W-1:0]  s2_sum, quo_n;
  logic [QW-1:0]     s2_q;
  // stage 3: signed offset added to reference
  logic              s3_v;
  logic [TIME_W-1:0] s3_ref, s3_avg, avg_n;
  logic [CNT_W-1:0]  s3_cnt;
  logic [SUM_W-1:0]  s3_sum;
  logic [QW:0]       soff;

  always_comb begin
    mag_n = in_sum[SUM_W-1] ? (~in_sum + SUM_W'(1)) : in_sum;
    quo_n = s1_mag / {{(SUM_W-CNT_W){1'b0}}, s1_cnt};
    soff  = s2_neg ? (~{1'b0, s2_q} + (QW+1)'(1)) : {1'b0, s2_q};
    avg_n = s2_ref + {{EXW{soff[QW]}}, soff};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_neg <= 1'b0; s1_ref <= '0; s1_cnt <= '0; s1_sum <= '0; s1_mag <= '0;
      s2_v <= 1'b0; s2_neg <= 1'b0; s2_ref <= '0; s2_cnt <= '0; s2_sum <= '0; s2_q <= '0;
      s3_v <= 1'b0; s3_ref <= '0; s3_cnt <= '0; s3_sum <= '0; s3_avg <= '0;
    end else begin
      s1_v <= in_v;
      s2_v <= s1_v;
      s3_v <= s2_v;
      if (in_v) begin
        s1_neg <= in_sum[SUM_W-1];
        s1_ref <= in_ref;
        s1_cnt <= in_cnt;
        s1_sum <= in_sum;
        s1_mag <= mag_n;
      end
      if (s1_v) begin
        s2_neg <= s1_neg;
        s2_ref <= s1_ref;
        s2_cnt <= s1_cnt;
        s2_sum <= s1_sum;
        s2_q   <= quo_n[QW-1:0];
      end
      if (s2_v) begin
        s3_ref <= s2_ref;
        s3_cnt <= s2_cnt;
        s3_sum <= s2_sum;
        s3_avg <= avg_n;
      end
    end
  end

  assign out_v   = s3_v;
  assign out_ref = s3_ref;
  assign out_cnt = s3_cnt;
  assign out_sum = s3_sum;
  assign out_avg = s3_avg;

  // R8
  avg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |=> ##2 out_v);
  // R8
  avg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> (out_cnt != '0));
endmodule

// File: rtl/hit_cluster_chain.sv
`timescale 1ns/1ps
module hit_cluster_chain #(
  parameter int N_CELLS  = 32,
  parameter int COARSE_W = 32,
  parameter int FINE_W   = 8,
  parameter int WIN_W    = 8,
  parameter int CNT_W    = 8,
  localparam int TIME_W  = COARSE_W + FINE_W,
  localparam int SUM_W   = WIN_W + 2 + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [TIME_W-1:0] hit_time,
  input  logic              frame_end,
  input  logic [WIN_W-1:0]  win_lo,
  input  logic [WIN_W-1:0]  win_hi,
  output logic              hit_ready,
  output logic              clu_valid,
  output logic [TIME_W-1:0] clu_ref,
  output logic [CNT_W-1:0]  clu_cnt,
  output logic [SUM_W-1:0]  clu_sum,
  output logic [TIME_W-1:0] clu_avg,
  output logic              hit_lost
);
  // token links: index i feeds cell i, index N_CELLS leaves the chain
  logic              tok_v [N_CELLS+1];
  logic [TIME_W-1:0] tok_t [N_CELLS+1];
  // cell state, index N_CELLS is the empty filler shifted into the tail
  logic              c_occ [N_CELLS+1];
  logic [TIME_W-1:0] c_ref [N_CELLS+1];
  logic [CNT_W-1:0]  c_cnt [N_CELLS+1];
  logic [SUM_W-1:0]  c_sum [N_CELLS+1];

  logic accept, shift, any_tok, lost_q, in_ld;
  logic [N_CELLS-1:0] tok_vec;

  assign c_occ[N_CELLS] = 1'b0;
  assign c_ref[N_CELLS] = '0;
  assign c_cnt[N_CELLS] = '0;
  assign c_sum[N_CELLS] = '0;

  assign in_ld = hit_valid & accept;

  // entry register in front of cell 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_v[0] <= 1'b0;
      tok_t[0] <= '0;
    end else begin
      tok_v[0] <= in_ld;
      if (in_ld) tok_t[0] <= hit_time;
    end
  end

  for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
    assign tok_vec[gi] = tok_v[gi];
    tclu_cell #(.TIME_W(TIME_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift),
      .win_lo   (win_lo),
      .win_hi   (win_hi),
      .tok_v_i  (tok_v[gi]),
      .tok_t_i  (tok_t[gi]),
      .nb_occ_i (c_occ[gi+1]),
      .nb_ref_i (c_ref[gi+1]),
      .nb_cnt_i (c_cnt[gi+1]),
      .nb_sum_i (c_sum[gi+1]),
      .occ_o    (c_occ[gi]),
      .ref_o    (c_ref[gi]),
      .cnt_o    (c_cnt[gi]),
      .sum_o    (c_sum[gi]),
      .tok_v_o  (tok_v[gi+1]),
      .tok_t_o  (tok_t[gi+1])
    );
  end

  assign any_tok = |tok_vec;

  tclu_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .any_tok   (any_tok),
    .head_occ  (c_occ[0]),
    .accept_o  (accept),
    .shift_o   (shift)
  );

  tclu_avg #(.TIME_W(TIME_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) avg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v    (shift & c_occ[0]),
    .in_ref  (c_ref[0]),
    .in_cnt  (c_cnt[0]),
    .in_sum  (c_sum[0]),
    .out_v   (clu_valid),
    .out_ref (clu_ref),
    .out_cnt (clu_cnt),
    .out_sum (clu_sum),
    .out_avg (clu_avg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lost_q <= 1'b0;
    else if (tok_v[N_CELLS]) lost_q <= 1'b1;
  end

  assign hit_ready = accept;
  assign hit_lost  = lost_q;

  // R6
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |=> lost_q);
  // R6
  lost_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_v[N_CELLS] |=> lost_q);
  // R7
  busy_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ready |=> !tok_v[0]);
endmodule

// File: tb/hit_cluster_chain_tb_top.sv
`timescale 1ns/1ps
module hit_cluster_chain_tb_top;
  localparam int N_CELLS = 32;
  localparam int TIME_W  = 40;
  localparam int WIN_W   = 8;
  localparam int CNT_W   = 8;
  localparam int SUM_W   = WIN_W + 2 + CNT_W;
  localparam int MAXB    = 64;

  logic clk, rst_n;
  logic hit_valid, frame_end, hit_ready, clu_valid, hit_lost;
  logic [TIME_W-1:0] hit_time, clu_ref, clu_avg;
  logic [WIN_W-1:0]  win_lo, win_hi;
  logic [CNT_W-1:0]  clu_cnt;
  logic [SUM_W-1:0]  clu_sum;

  hit_cluster_chain dut_i (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_time(hit_time),
    .frame_end(frame_end), .win_lo(win_lo), .win_hi(win_hi),
    .hit_ready(hit_ready), .clu_valid(clu_valid), .clu_ref(clu_ref),
    .clu_cnt(clu_cnt), .clu_sum(clu_sum), .clu_avg(clu_avg), .hit_lost(hit_lost)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk, n_fail, cyc;
  initial begin n_chk = 0; n_fail = 0; cyc = 0; end
  always @(posedge clk) cyc <= cyc + 1;

  // model state
  longint m_ref [N_CELLS];
  longint m_sum [N_CELLS];
  int     m_cnt [N_CELLS];
  int     m_n;
  // stimulus and capture buffers
  longint hbuf [MAXB];
  longint g_ref [MAXB];
  longint g_avg [MAXB];
  longint g_sum [MAXB];
  int     g_cnt [MAXB];
  int     g_cyc [MAXB];
  int     g_n;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && clu_valid === 1'b1 && g_n < MAXB) begin
      g_ref[g_n] = longint'(clu_ref);
      g_avg[g_n] = longint'(clu_avg);
      g_sum[g_n] = longint'($signed(clu_sum));
      g_cnt[g_n] = int'(clu_cnt);
      g_cyc[g_n] = cyc;
      g_n = g_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sequential greedy model of the chain
  function automatic void m_add(input longint t, input int lo, input int hi);
    for (int i = 0; i < m_n; i++) begin
      longint d = t - m_ref[i];
      if (d >= -longint'(lo) && d <= longint'(hi)) begin
        m_cnt[i] = m_cnt[i] + 1;
        m_sum[i] = m_sum[i] + d;
        return;
      end
    end
    if (m_n < N_CELLS) begin
      m_ref[m_n] = t;
      m_cnt[m_n] = 1;
      m_sum[m_n] = 0;
      m_n = m_n + 1;
    end
  endfunction

  function automatic longint m_avg(input int i);
    return m_ref[i] + (m_sum[i] / longint'(m_cnt[i]));
  endfunction

  task automatic run_frame(input int nh, input int lo, input int hi,
                           input bit poke_busy, input bit chk_lat);
    int c0;
    win_lo = WIN_W'(lo);
    win_hi = WIN_W'(hi);
    m_n = 0;
    g_n = 0;
    @(negedge clk);
    chk(hit_ready == 1'b1, "R7 ready before frame", longint'(hit_ready), 1);
    for (int i = 0; i < nh; i++) begin
      hit_valid = 1'b1;
      hit_time  = TIME_W'(hbuf[i]);
      m_add(hbuf[i], lo, hi);
      @(negedge clk);
    end
    hit_valid = 1'b0;
    repeat (N_CELLS + 2) @(negedge clk);
    frame_end = 1'b1;
    c0 = cyc;
    @(negedge clk);
    frame_end = 1'b0;
    chk(hit_ready == 1'b0, "R7 busy after strobe", longint'(hit_ready), 0);
    while (hit_ready !== 1'b1) begin
      if (poke_busy) begin
        hit_valid = 1'b1;
        hit_time  = TIME_W'(64'h77_0000_0000);
      end
      @(negedge clk);
      hit_valid = 1'b0;
    end
    repeat (5) @(negedge clk);
    chk(g_n == m_n, "R7 cluster count", g_n, m_n);
    for (int i = 0; i < m_n && i < g_n; i++) begin
      chk(g_ref[i] == m_ref[i], "R4 reference order", g_ref[i], m_ref[i]);
      chk(g_cnt[i] == m_cnt[i], "R3 member count", g_cnt[i], m_cnt[i]);
      chk(g_sum[i] == m_sum[i], "R3 offset sum", g_sum[i], m_sum[i]);
      chk(g_avg[i] == m_avg(i), "R8 average", g_avg[i], m_avg(i));
      if (chk_lat)
        chk(g_cyc[i] == c0 + 5 + i, "R8 output timing", g_cyc[i] - c0, 5 + i);
    end
  endtask

  initial begin
    longint b;
    rst_n = 1'b0;
    hit_valid = 1'b0; frame_end = 1'b0; hit_time = '0;
    win_lo = '0; win_hi = '0;
    g_n = 0; m_n = 0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    chk(hit_ready == 1'b1, "R1 ready in reset", longint'(hit_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_ready == 1'b1, "R1 ready", longint'(hit_ready), 1);
    chk(clu_valid == 1'b0, "R1 no output", longint'(clu_valid), 0);
    chk(hit_lost == 1'b0, "R1 lost clear", longint'(hit_lost), 0);

    // R5 window edges, R2 capture, R4 pass-down
    b = 64'd100000;
    hbuf[0] = b;      hbuf[1] = b + 50; hbuf[2] = b - 20;
    hbuf[3] = b + 51; hbuf[4] = b - 21; hbuf[5] = b + 60;
    run_frame(6, 20, 50, 1'b0, 1'b1);
    chk(g_n == 3, "R5 edge split", g_n, 3);
    if (g_n > 0) chk(g_cnt[0] == 3, "R5 both edges join", g_cnt[0], 3);

    // R8 truncation toward zero with a negative offset sum
    hbuf[0] = 64'd500000; hbuf[1] = 64'd500000 - 7;
    hbuf[2] = 64'd900000; hbuf[3] = 64'd900000 + 7;
    run_frame(4, 10, 10, 1'b0, 1'b1);
    if (g_n > 0) chk(g_avg[0] == 64'd500000 - 3, "R8 trunc negative", g_avg[0], 64'd500000 - 3);
    if (g_n > 1) chk(g_avg[1] == 64'd900000 + 3, "R8 trunc positive", g_avg[1], 64'd900000 + 3);

    // R7 empty frame
    run_frame(0, 5, 5, 1'b0, 1'b0);
    chk(g_n == 0, "R7 empty frame", g_n, 0);

    // R7 hits offered while busy are ignored, here and in the next frame
    hbuf[0] = 64'd1234567; hbuf[1] = 64'd1234570;
    run_frame(2, 5, 5, 1'b1, 1'b1);
    hbuf[0] = 64'd2000000;
    run_frame(1, 5, 5, 1'b0, 1'b1);
    chk(g_n == 1, "R7 no stale hit", g_n, 1);

    // constrained random frames
    for (int f = 0; f < 8; f++) begin
      int lo = $urandom_range(125, 0);
      int hi = $urandom_range(125, 0);
      int nc = $urandom_range(8, 1);
      int nh = $urandom_range(30, 1);
      for (int i = 0; i < nh; i++) begin
        longint ctr = 64'd4000000 + longint'($urandom_range(nc - 1, 0)) * 64'd20000 + f * 64'd500000;
        hbuf[i] = ctr + longint'($urandom_range(300, 0)) - 64'd150;
      end
      run_frame(nh, lo, hi, 1'b0, 1'b1);
    end
    chk(hit_lost == 1'b0, "R6 no loss yet", longint'(hit_lost), 0);

    // R6 overflow of the chain
    for (int i = 0; i < N_CELLS + 1; i++) hbuf[i] = 64'd9000000 + i * 64'd1000;
    run_frame(N_CELLS + 1, 10, 10, 1'b0, 1'b1);
    chk(hit_lost == 1'b1, "R6 loss flagged", longint'(hit_lost), 1);
    chk(g_n == N_CELLS, "R6 surplus discarded", g_n, N_CELLS);
    hbuf[0] = 64'd3000000;
    run_frame(1, 10, 10, 1'b0, 1'b1);
    chk(hit_lost == 1'b1, "R6 loss sticky", longint'(hit_lost), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule